// File: doc/BRIEF.md
# AES Round Step Unit

This block carries out one step of an AES-style cipher round on a 128-bit state. The state is treated as a matrix of bytes with four rows and `NB` columns. A caller presents the state, the round key for this step, a round number and a mode code, and then pulses `start`. One clock later the block shows the transformed state and raises `done` for a single cycle. The result stays in place until the next `start`.

Four modes are available: a full round, substitution alone, row rotation alone, and key addition alone. The full round runs byte substitution, then row rotation, then key addition. When the round number is zero, the block performs only key addition, whatever the mode code says; this is the key addition made before the first round. The substitution table is not stored. Each byte is inverted in GF(2^8) and then passed through an affine map. Key expansion, column mixing, the inverse cipher and the sequencing of rounds are handled outside this block.

Top module: `aes_round_unit`

## Requirements
- R1: While `rstN` is low and after its release, until the first `start`, `stateOut` is all zeros and `done` is 0.
- R2: `done` is 1 in exactly the cycle that follows a cycle with `start` high and is 0 otherwise. When `start` is low, `stateOut` keeps its value.
- R3: Mode code 1 (substitute) replaces every byte x with S(x) = A(x^-1). The inverse is taken modulo x^8+x^4+x^3+x+1, with 0 mapped to 0. A sets bit i to b[i]^b[i+4]^b[i+5]^b[i+6]^b[i+7]^c[i] (indices mod 8) with c = 0x63. So S(0x00)=0x63 and S(0x53)=0xED.
- R4: Byte k of a state bus occupies bits [8k+7:8k] and sits at row k mod 4, column k div 4. Mode code 2 (rotate rows) places the old byte from row r, column (c+r) mod NB at row r, column c. Row 0 does not move.
- R5: Mode code 3 (key only) XORs the state with `roundKey`. Column c is combined with key word c, which is bits [32c+31:32c]. For example, 0x53 XOR 0xCA = 0x99.
- R6: Mode code 0 (full round) gives KEY(ROT(SUB(stateIn))), in that order.
- R7: When `roundIdx` is 0, the result is `stateIn` XOR `roundKey` for every mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Applies one step this cycle |
| roundType | input | 2 | Mode: 0 full, 1 substitute, 2 rotate rows, 3 key only |
| roundIdx | input | ROUND_W (4) | Round number; 0 forces key only |
| stateIn | input | NB*32 (128) | Input state, column-major bytes |
| roundKey | input | NB*32 (128) | Round key, word c for column c |
| stateOut | output | NB*32 (128) | Registered result state |
| done | output | 1 | One-cycle pulse when stateOut updates |

## Verification
The bench uses the default build with NB = 4 and ROUND_W = 4. This gives the full 128-bit state, so all three non-zero row rotations can be seen, and round numbers 0 through 15, so both the forced key-only path at round 0 and ordinary rounds can be reached. Sixteen substitute-only steps push all 256 byte values through the sixteen S-box lanes. The results are compared with a model in the bench that finds each inverse by search. A counting pattern, byte k equal to k, makes every rotation of the rows visible.

// File: rtl/aes_rt_pkg.sv
package aes_rt_pkg;

  typedef enum logic [1:0] {
    RT_FULL  = 2'd0,
    RT_SUB   = 2'd1,
    RT_SHIFT = 2'd2,
    RT_KEY   = 2'd3
  } rtMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic doSub;
    logic doShift;
    logic doKey;
  } rtCtrl_t;

  // GF(2^8) product, reduction polynomial 0x11B
  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] run;
    acc = 8'h00;
    run = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ run;
      run = {run[6:0], 1'b0} ^ (run[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // inverse as a^254 by square-and-multiply; 0 yields 0
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    logic [7:0] expo;
    res  = 8'h01;
    pw   = a;
    expo = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (expo[i]) res = gfMul(res, pw);
      pw = gfMul(pw, pw);
    end
    return res;
  endfunction

endpackage

// File: rtl/aes_rt_sbox.sv
module aes_rt_sbox
  import aes_rt_pkg::*;
(
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  localparam logic [7:0] AFFINE_C = 8'h63;

  logic [7:0] invByte;

  always_comb begin
    invByte = gfInv(byteIn);
    // affine map as XOR of left rotations 0..4 plus constant
    byteOut = invByte
            ^ {invByte[6:0], invByte[7]}
            ^ {invByte[5:0], invByte[7:6]}
            ^ {invByte[4:0], invByte[7:5]}
            ^ {invByte[3:0], invByte[7:4]}
            ^ AFFINE_C;
  end
endmodule

// File: rtl/aes_rt_ctrl.sv
module aes_rt_ctrl
  import aes_rt_pkg::*;
#(
  parameter int ROUND_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         roundType,
  input  logic [ROUND_W-1:0] roundIdx,
  output rtCtrl_t            ctrl,
  output logic               done
);
  rtMode_e mode;
  logic    keyOnly;

  always_comb begin
    mode         = rtMode_e'(roundType);
    keyOnly      = (roundIdx == '0) || (mode == RT_KEY);
    ctrl.load    = start;
    ctrl.doSub   = !keyOnly && (mode == RT_FULL || mode == RT_SUB);
    ctrl.doShift = !keyOnly && (mode == RT_FULL || mode == RT_SHIFT);
    ctrl.doKey   = keyOnly || (mode == RT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/aes_rt_datapath.sv
module aes_rt_datapath
  import aes_rt_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtCtrl_t           ctrl,
  input  logic [NB*32-1:0]  stateIn,
  input  logic [NB*32-1:0]  roundKey,
  output logic [NB*32-1:0]  stateOut
);
  localparam int ROWS    = 4;
  localparam int NBYTES  = ROWS * NB;
  localparam int STATE_W = NBYTES * 8;

  logic [STATE_W-1:0] subAll;
  logic [STATE_W-1:0] subSel;
  logic [STATE_W-1:0] rotAll;
  logic [STATE_W-1:0] rotSel;
  logic [STATE_W-1:0] keySel;

  genvar gb, gr, gc;
  generate
    for (gb = 0; gb < NBYTES; gb++) begin : g_sbox
      aes_rt_sbox u_sbox (
        .byteIn (stateIn[8*gb +: 8]),
        .byteOut(subAll[8*gb +: 8])
      );
    end
    for (gr = 0; gr < ROWS; gr++) begin : g_row
      for (gc = 0; gc < NB; gc++) begin : g_col
        assign rotAll[8*(ROWS*gc + gr) +: 8] =
          subSel[8*(ROWS*((gc + gr) % NB) + gr) +: 8];
      end
    end
  endgenerate

  always_comb begin
    subSel = ctrl.doSub   ? subAll : stateIn;
    rotSel = ctrl.doShift ? rotAll : subSel;
    keySel = ctrl.doKey   ? (rotSel ^ roundKey) : rotSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          stateOut <= '0;
    else if (ctrl.load) stateOut <= keySel;
  end
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_rt_pkg::*;
#(
  parameter int NB      = 4,
  parameter int ROUND_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         roundType,
  input  logic [ROUND_W-1:0] roundIdx,
  input  logic [NB*32-1:0]   stateIn,
  input  logic [NB*32-1:0]   roundKey,
  output logic [NB*32-1:0]   stateOut,
  output logic               done
);
  rtCtrl_t ctrl;

  aes_rt_ctrl #(.ROUND_W(ROUND_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .roundType(roundType),
    .roundIdx (roundIdx),
    .ctrl     (ctrl),
    .done     (done)
  );

  aes_rt_datapath #(.NB(NB)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .stateIn (stateIn),
    .roundKey(roundKey),
    .stateOut(stateOut)
  );
endmodule

// File: rtl/aes_round_unit_chk.sv
module aes_round_unit_chk #(
  parameter int NB      = 4,
  parameter int ROUND_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [1:0]         roundType,
  input logic [ROUND_W-1:0] roundIdx,
  input logic [NB*32-1:0]   stateIn,
  input logic [NB*32-1:0]   roundKey,
  input logic [NB*32-1:0]   stateOut,
  input logic               done
);
  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(stateOut));

  p_key_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (start && roundType == 2'd3) |=> (stateOut == $past(stateIn ^ roundKey)));

  p_round_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && roundIdx == '0) |=> (stateOut == $past(stateIn ^ roundKey)));

  // row 0 stays put, row 1 column 0 takes row 1 column 1
  p_rotate_rows_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && roundType == 2'd2 && roundIdx != '0) |=>
      (stateOut[7:0] == $past(stateIn[7:0]) && stateOut[15:8] == $past(stateIn[47:40])));
endmodule

bind aes_round_unit aes_round_unit_chk #(.NB(NB), .ROUND_W(ROUND_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .roundType(roundType),
  .roundIdx(roundIdx), .stateIn(stateIn), .roundKey(roundKey),
  .stateOut(stateOut), .done(done)
);

// File: tb/aes_round_unit_tb.sv
module aes_round_unit_tb;
  localparam int NB = 4;
  localparam int RW = 4;
  localparam int SW = NB * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    roundType = 2'd0;
  logic [RW-1:0] roundIdx = '0;
  logic [SW-1:0] stateIn = '0;
  logic [SW-1:0] roundKey = '0;
  logic [SW-1:0] stateOut;
  logic          done;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  int sboxRef [256];

  logic [SW-1:0] expState = '0;
  logic          expDone = 1'b0;

  always #5 clk = ~clk;

  aes_round_unit #(.NB(NB), .ROUND_W(RW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .roundType(roundType),
    .roundIdx(roundIdx), .stateIn(stateIn), .roundKey(roundKey),
    .stateOut(stateOut), .done(done)
  );

  function automatic int mulRef(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) begin
      if (((b >> i) & 1) == 1) p = p ^ a;
      a = a << 1;
      if (a > 255) a = (a ^ 'h11B);
    end
    return p;
  endfunction

  function automatic int invRef(int x);
    if (x == 0) return 0;
    for (int y = 1; y < 256; y++) if (mulRef(x, y) == 1) return y;
    return 0;
  endfunction

  function automatic int affRef(int b);
    int o = 0;
    for (int i = 0; i < 8; i++) begin
      int bit_v;
      bit_v = ((b >> i) ^ (b >> ((i + 4) % 8)) ^ (b >> ((i + 5) % 8)) ^
               (b >> ((i + 6) % 8)) ^ (b >> ((i + 7) % 8)) ^ ('h63 >> i)) & 1;
      o = o | (bit_v << i);
    end
    return o;
  endfunction

  function automatic logic [SW-1:0] subRef(logic [SW-1:0] s);
    logic [SW-1:0] o;
    for (int k = 0; k < 4 * NB; k++) o[8*k +: 8] = 8'(sboxRef[int'(s[8*k +: 8])]);
    return o;
  endfunction

  function automatic logic [SW-1:0] rotRef(logic [SW-1:0] s);
    logic [SW-1:0] o;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < NB; c++)
        o[8*(4*c + r) +: 8] = s[8*(4*((c + r) % NB) + r) +: 8];
    return o;
  endfunction

  function automatic logic [SW-1:0] stepRef(logic [1:0] t, logic [RW-1:0] idx,
                                            logic [SW-1:0] s, logic [SW-1:0] k);
    if (idx == 0 || t == 2'd3) return s ^ k;
    case (t)
      2'd1:    return subRef(s);
      2'd2:    return rotRef(s);
      default: return rotRef(subRef(s)) ^ k;
    endcase
  endfunction

  // reference model, one step per clock
  always @(posedge clk) begin
    if (!rstN) begin
      expState <= '0;
      expDone  <= 1'b0;
    end else begin
      expDone <= start;
      if (start) expState <= stepRef(roundType, roundIdx, stateIn, roundKey);
    end
  end

  // per-cycle comparison (R1, R2 and all modes)
  always @(negedge clk) begin
    if (!finished) begin
      nChecks++;
      if (stateOut !== expState || done !== expDone) begin
        nFails++;
        $display("FAIL R2/model: stateOut=%h done=%b expected stateOut=%h done=%b",
                 stateOut, done, expState, expDone);
      end
    end
  end

  task automatic check(string tag, logic [SW-1:0] got, logic [SW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic [1:0] t, logic [RW-1:0] idx, logic [SW-1:0] s, logic [SW-1:0] k);
    @(negedge clk);
    start = 1'b1; roundType = t; roundIdx = idx; stateIn = s; roundKey = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  logic [SW-1:0] cnt;
  logic [SW-1:0] expRot;

  initial begin
    for (int x = 0; x < 256; x++) sboxRef[x] = affRef(invRef(x));
    for (int k = 0; k < 16; k++) cnt[8*k +: 8] = 8'(k);
    // counting pattern after row rotation, written from the byte rule
    expRot = {8'h0B, 8'h06, 8'h01, 8'h0C, 8'h07, 8'h02, 8'h0D, 8'h08,
              8'h03, 8'h0E, 8'h09, 8'h04, 8'h0F, 8'h0A, 8'h05, 8'h00};

    repeat (3) @(negedge clk);
    check("R1 reset state", stateOut, '0);
    check("R1 reset done", {127'd0, done}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", stateOut, '0);

    // R3 fixed points
    step(2'd1, 4'd1, {{15{8'h00}}, 8'h53}, '0);
    check("R3 S(53)", stateOut, {{15{8'h63}}, 8'hED});
    check("R2 done pulse", {127'd0, done}, 128'd1);
    @(negedge clk);
    check("R2 done low", {127'd0, done}, '0);
    check("R2 hold", stateOut, {{15{8'h63}}, 8'hED});

    // R3 whole table through sixteen lanes
    for (int blk = 0; blk < 16; blk++) begin
      logic [SW-1:0] s;
      logic [SW-1:0] e;
      for (int k = 0; k < 16; k++) begin
        s[8*k +: 8] = 8'(16 * blk + k);
        e[8*k +: 8] = 8'(sboxRef[16 * blk + k]);
      end
      step(2'd1, 4'd5, s, '1);
      check("R3 sbox block", stateOut, e);
    end

    // R4 rotate rows on counting pattern
    step(2'd2, 4'd2, cnt, '1);
    check("R4 counting pattern", stateOut, expRot);

    // R5 key add, 0x53 ^ 0xCA
    step(2'd3, 4'd7, {16{8'h53}}, {16{8'hCA}});
    check("R5 key xor", stateOut, {16{8'h99}});

    // R6 full round order
    step(2'd0, 4'd3, cnt, 128'h0123456789ABCDEF_FEDCBA9876543210);
    check("R6 full round", stateOut, rotRef(subRef(cnt)) ^ 128'h0123456789ABCDEF_FEDCBA9876543210);

    // R7 round zero forces key only, for every mode
    for (int t = 0; t < 4; t++) begin
      step(2'(t), 4'd0, cnt, {16{8'hA5}});
      check("R7 round zero", stateOut, cnt ^ {16{8'hA5}});
    end

    // back-to-back starts
    @(negedge clk);
    start = 1'b1; roundType = 2'd0; roundIdx = 4'd9; stateIn = {16{8'h53}}; roundKey = '0;
    @(negedge clk);
    check("R6 back-to-back first", stateOut, rotRef(subRef({16{8'h53}})));
    roundType = 2'd2; stateIn = cnt;
    @(negedge clk);
    start = 1'b0;
    check("R4 back-to-back second", stateOut, expRot);
    check("R2 done held high", {127'd0, done}, 128'd1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule